// File: doc/BRIEF.md
# Address-Tagged Packet Receiver

This block sits behind a UART receiver that already turns the line into 9-bit characters. Each accepted character carries a byte, a ninth tag bit and three line-error flags. A character with the tag bit set is an address. The sync address opens a packet whose length is fixed by the size of a row buffer. The untagged characters that follow are written, in arrival order, into the buffer. When the last expected byte lands, a completion flag is raised.

The host picks a row with a row index and reads the stored bytes on a combinational read port. It clears the completion flag with a one-cycle acknowledge. Other address values close reception, so that traffic meant for other destinations is skipped. Any character that arrives with a line error abandons the packet in progress.

The buffer is `ROWS` rows of `ROW_BYTES` bytes, so one packet is `ROWS*ROW_BYTES` bytes. The sync address value is the parameter `SYNC_ADDR`, which defaults to 0x01.

Top module: `tagged_frame_rx`

## Requirements
- R1: After reset `synced` is 0 and every row reads as all zeros.
- R2: An accepted character with `chr_tag`=1, no error flag and `chr_data`==`SYNC_ADDR` opens a packet of `ROWS*ROW_BYTES` bytes. The k-th following data character (`chr_tag`=0) is stored in row k/`ROW_BYTES`, in bits [8*(k mod `ROW_BYTES`)+7 : 8*(k mod `ROW_BYTES`)] of that row, so byte 0 lands in the low bits.
- R3: An accepted error-free address character with any other value closes reception. The data characters that follow change no row and do not raise `synced`.
- R4: A character with `err_frame`, `err_overrun` or `err_parity` set is discarded, whatever its tag. It also abandons any open packet, so the data characters that follow are ignored until the next sync address.
- R5: `synced` rises in the cycle after the clock edge that accepts the last byte of a packet, and never earlier within the packet.
- R6: Data characters that arrive while no packet is open are ignored, and this includes bytes beyond the packet length.
- R7: An `ack` pulse clears `synced` at the next edge. If the last byte of a packet is accepted at the same edge as an `ack`, `synced` ends up set.
- R8: A sync address that arrives inside an open packet restarts it at byte 0 with the full count. Bytes written before the restart stay in the buffer until they are overwritten.
- R9: While `chr_valid` is 0, the other character inputs have no effect.
- R10: `rd_data` shows row `rd_row` in the same cycle, and reads as zero for an index of `ROWS` or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | One-cycle strobe for a received character |
| chr_data | input | 8 | Character byte |
| chr_tag | input | 1 | Ninth bit; 1 marks an address |
| err_frame | input | 1 | Framing error on this character |
| err_overrun | input | 1 | Overrun error on this character |
| err_parity | input | 1 | Parity error on this character |
| ack | input | 1 | Host clears the completion flag |
| rd_row | input | ROW_IDX_W | Row selected for reading |
| rd_data | output | 8*ROW_BYTES | Content of the selected row |
| synced | output | 1 | A complete packet has been stored |

## Verification
The bench builds the block with three rows of two bytes, which gives a six-byte packet. Because that length is not a power of two, the row index has an out-of-range value to probe, and the byte pointer never wraps cleanly. With two bytes per row, a restarted packet leaves a row that is half old and half new, so R8 can be checked on a single row. This shape also lets the bench land a completion and an acknowledge on the same edge after only a few characters.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

   // Classification of one input character
   typedef enum logic [2:0] {
      CK_NONE    = 3'd0,
      CK_FAULT   = 3'd1,
      CK_OPEN    = 3'd2,
      CK_FOREIGN = 3'd3,
      CK_DATA    = 3'd4
   } chr_kind_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/tfr_char_classify.sv
module tfr_char_classify #(
   parameter logic [7:0] SYNC_ADDR = 8'h01
) (
   input  logic                 chr_valid,
   input  logic [7:0]           chr_data,
   input  logic                 chr_tag,
   input  logic                 err_frame,
   input  logic                 err_overrun,
   input  logic                 err_parity,
   output tfr_pkg::chr_kind_e   kind
);
   import tfr_pkg::*;

   logic any_err;

   assign any_err = err_frame | err_overrun | err_parity;

   always_comb begin
      kind = CK_NONE;
      if (chr_valid) begin
         if (any_err)
            kind = CK_FAULT;                         // R4
         else if (chr_tag && chr_data == SYNC_ADDR)
            kind = CK_OPEN;                          // R2
         else if (chr_tag)
            kind = CK_FOREIGN;                       // R3
         else
            kind = CK_DATA;
      end
   end

endmodule

// File: rtl/tfr_frame_ctrl.sv
module tfr_frame_ctrl #(
   parameter int unsigned TOTAL = 8,
   localparam int unsigned CNT_W = $clog2(TOTAL + 1),
   localparam int unsigned IDX_W = tfr_pkg::idx_width(TOTAL)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  tfr_pkg::chr_kind_e  kind,
   output logic                wr_en,
   output logic [IDX_W-1:0]    wr_idx,
   output logic                last_byte,
   output logic [CNT_W-1:0]    remain
);
   import tfr_pkg::*;

   logic [IDX_W-1:0] idx_q;

   assign wr_en     = (kind == CK_DATA) && (remain != '0);    // R6
   assign wr_idx    = idx_q;
   assign last_byte = wr_en && (remain == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         idx_q  <= '0;
      end else begin
         unique case (kind)
            CK_FAULT, CK_FOREIGN: remain <= '0;               // R3 R4
            CK_OPEN: begin                                    // R8
               remain <= CNT_W'(TOTAL);
               idx_q  <= '0;
            end
            CK_DATA: begin
               if (remain != '0) begin
                  remain <= remain - CNT_W'(1);
                  idx_q  <= idx_q + IDX_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/tfr_row_store.sv
module tfr_row_store #(
   parameter int unsigned ROWS      = 4,
   parameter int unsigned ROW_BYTES = 2,
   localparam int unsigned TOTAL     = ROWS * ROW_BYTES,
   localparam int unsigned IDX_W     = tfr_pkg::idx_width(TOTAL),
   localparam int unsigned ROW_IDX_W = tfr_pkg::idx_width(ROWS + 1),
   localparam int unsigned ROW_W     = 8 * ROW_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [IDX_W-1:0]     wr_idx,
   input  logic [7:0]           wr_byte,
   input  logic [ROW_IDX_W-1:0] rd_row,
   output logic [ROW_W-1:0]     rd_data
);

   logic [ROW_W-1:0] rows [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar l = 0; l < ROW_BYTES; l++) begin : g_lane
         localparam int unsigned POS = r * ROW_BYTES + l;
         logic hit;
         assign hit = wr_en && (wr_idx == IDX_W'(POS));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rows[r][8*l +: 8] <= 8'h00;                   // R1
            else if (hit)
               rows[r][8*l +: 8] <= wr_byte;                 // R2
         end
      end
   end

   if (ROWS == 1) begin : g_rd_single
      assign rd_data = (rd_row == '0) ? rows[0] : '0;
   end else begin : g_rd_mux
      always_comb begin                                      // R10
         rd_data = '0;
         for (int i = 0; i < ROWS; i++)
            if (rd_row == ROW_IDX_W'(i))
               rd_data = rows[i];
      end
   end

endmodule

// File: rtl/tfr_done_flag.sv
module tfr_done_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack,
   output logic synced
);

   // completion wins over a same-edge acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         synced <= 1'b0;
      else if (set_i)
         synced <= 1'b1;                                     // R5
      else if (ack)
         synced <= 1'b0;                                     // R7
   end

endmodule

// File: rtl/tagged_frame_rx.sv
module tagged_frame_rx #(
   parameter int unsigned ROWS      = 4,
   parameter int unsigned ROW_BYTES = 2,
   parameter logic [7:0]  SYNC_ADDR = 8'h01,
   localparam int unsigned TOTAL     = ROWS * ROW_BYTES,
   localparam int unsigned CNT_W     = $clog2(TOTAL + 1),
   localparam int unsigned IDX_W     = tfr_pkg::idx_width(TOTAL),
   localparam int unsigned ROW_IDX_W = tfr_pkg::idx_width(ROWS + 1),
   localparam int unsigned ROW_W     = 8 * ROW_BYTES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 chr_valid,
   input  logic [7:0]           chr_data,
   input  logic                 chr_tag,
   input  logic                 err_frame,
   input  logic                 err_overrun,
   input  logic                 err_parity,
   input  logic                 ack,
   input  logic [ROW_IDX_W-1:0] rd_row,
   output logic [ROW_W-1:0]     rd_data,
   output logic                 synced
);
   import tfr_pkg::*;

   if (ROWS < 1) begin : g_bad_rows
      $error("tagged_frame_rx: ROWS must be at least 1");
   end
   if (ROW_BYTES < 1) begin : g_bad_bytes
      $error("tagged_frame_rx: ROW_BYTES must be at least 1");
   end
   if (TOTAL > 4096) begin : g_bad_total
      $error("tagged_frame_rx: buffer too large");
   end

   chr_kind_e        kind;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic             last_byte;
   logic [CNT_W-1:0] remain;

   tfr_char_classify #(.SYNC_ADDR(SYNC_ADDR)) u_cls (
      .chr_valid  (chr_valid),
      .chr_data   (chr_data),
      .chr_tag    (chr_tag),
      .err_frame  (err_frame),
      .err_overrun(err_overrun),
      .err_parity (err_parity),
      .kind       (kind)
   );

   tfr_frame_ctrl #(.TOTAL(TOTAL)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .last_byte(last_byte),
      .remain   (remain)
   );

   tfr_row_store #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_byte(chr_data),
      .rd_row (rd_row),
      .rd_data(rd_data)
   );

   tfr_done_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (last_byte),
      .ack   (ack),
      .synced(synced)
   );

endmodule

// File: rtl/tagged_frame_rx_chk.sv
module tagged_frame_rx_chk #(
   parameter int unsigned TOTAL     = 8,
   parameter logic [7:0]  SYNC_ADDR = 8'h01,
   parameter int unsigned CNT_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             chr_valid,
   input logic [7:0]       chr_data,
   input logic             chr_tag,
   input logic             err_frame,
   input logic             err_overrun,
   input logic             err_parity,
   input logic             ack,
   input logic             synced,
   input logic [CNT_W-1:0] remain
);

   logic bad;
   assign bad = err_frame | err_overrun | err_parity;

   AST_REMAIN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      remain <= CNT_W'(TOTAL));                                            // R2

   AST_SYNC_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      chr_valid && !bad && chr_tag && chr_data == SYNC_ADDR
      |=> remain == CNT_W'(TOTAL));                                        // R8

   AST_FOREIGN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      chr_valid && !bad && chr_tag && chr_data != SYNC_ADDR
      |=> remain == '0);                                                   // R3

   AST_FAULT_ABANDONS: assert property (@(posedge clk) disable iff (!rst_n)
      chr_valid && bad |=> remain == '0);                                  // R4

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !chr_valid |=> $stable(remain));                                     // R9

   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(synced) |-> remain == '0 && $past(chr_valid) && !$past(chr_tag)); // R5

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !chr_valid |=> !synced);                                      // R7

   AST_NO_DATA_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !synced && remain == '0 |=> !synced);                                // R6

endmodule

bind tagged_frame_rx tagged_frame_rx_chk #(
   .TOTAL(TOTAL), .SYNC_ADDR(SYNC_ADDR), .CNT_W(CNT_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
   .chr_tag(chr_tag), .err_frame(err_frame), .err_overrun(err_overrun),
   .err_parity(err_parity), .ack(ack), .synced(synced), .remain(remain)
);

// File: tb/tagged_frame_rx_tb_top.sv
`timescale 1ns/1ps
module tagged_frame_rx_tb_top;

   localparam int unsigned NR  = 3;
   localparam int unsigned NB  = 2;
   localparam int unsigned TOT = NR * NB;
   localparam int unsigned RIW = (NR + 1 > 1) ? $clog2(NR + 1) : 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           chr_valid = 1'b0;
   logic [7:0]     chr_data = 8'h00;
   logic           chr_tag = 1'b0;
   logic           err_frame = 1'b0, err_overrun = 1'b0, err_parity = 1'b0;
   logic           ack = 1'b0;
   logic [RIW-1:0] rd_row = '0;
   logic [8*NB-1:0] rd_data;
   logic           synced;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #10 clk = ~clk;   // 50 MHz

   tagged_frame_rx #(.ROWS(NR), .ROW_BYTES(NB), .SYNC_ADDR(8'h01)) dut_i (
      .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
      .chr_tag(chr_tag), .err_frame(err_frame), .err_overrun(err_overrun),
      .err_parity(err_parity), .ack(ack), .rd_row(rd_row),
      .rd_data(rd_data), .synced(synced)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0] mb [TOT];
   int         m_rem = 0;
   int         m_ptr = 0;
   bit         m_sync = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < TOT; i++) mb[i] = 8'h00;
         m_rem = 0; m_ptr = 0; m_sync = 1'b0;
      end else begin
         if (ack) m_sync = 1'b0;
         if (chr_valid) begin
            if (err_frame || err_overrun || err_parity) m_rem = 0;
            else if (chr_tag) begin
               if (chr_data == 8'h01) begin m_rem = TOT; m_ptr = 0; end
               else m_rem = 0;
            end else if (m_rem > 0) begin
               mb[m_ptr] = chr_data;
               m_ptr++;
               m_rem--;
               if (m_rem == 0) m_sync = 1'b1;
            end
         end
      end
   end

   function automatic logic [8*NB-1:0] model_row(input int r);
      logic [8*NB-1:0] v = '0;
      if (r < NR)
         for (int l = 0; l < NB; l++) v[8*l +: 8] = mb[r*NB + l];
      return v;
   endfunction

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (synced !== m_sync) begin
            errors++;
            $display("FAIL R5/R7 cycle compare synced: actual=%0b expected=%0b", synced, m_sync);
         end
         checks++;
         if (rd_data !== model_row(int'(rd_row))) begin
            errors++;
            $display("FAIL R2/R10 cycle compare row %0d: actual=%h expected=%h",
                     rd_row, rd_data, model_row(int'(rd_row)));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic send(input bit tag, input logic [7:0] d,
                       input bit fe = 0, input bit oe = 0, input bit pe = 0,
                       input bit ak = 0);
      @(negedge clk); #2;
      chr_valid = 1'b1; chr_tag = tag; chr_data = d;
      err_frame = fe; err_overrun = oe; err_parity = pe; ack = ak;
      @(posedge clk); #2;
      chr_valid = 1'b0; ack = 1'b0;
      err_frame = 1'b0; err_overrun = 1'b0; err_parity = 1'b0;
   endtask

   task automatic idle_junk(input bit tag, input logic [7:0] d);
      @(negedge clk); #2;
      chr_valid = 1'b0; chr_tag = tag; chr_data = d; err_parity = 1'b1;
      @(posedge clk); #2;
      err_parity = 1'b0;
   endtask

   task automatic pulse_ack();
      @(negedge clk); #2; ack = 1'b1;
      @(posedge clk); #2; ack = 1'b0;
   endtask

   task automatic expect_sync(input bit exp, input string tag);
      checks++;
      if (synced !== exp) begin
         errors++;
         $display("FAIL %s synced: actual=%0b expected=%0b", tag, synced, exp);
      end
   endtask

   task automatic expect_row(input int r, input logic [8*NB-1:0] exp, input string tag);
      rd_row = RIW'(r);
      #1;
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s row %0d: actual=%h expected=%h", tag, r, rd_data, exp);
      end
      rd_row = '0;
   endtask

   task automatic finish_run();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      #3;
      // R1 reset state
      expect_sync(1'b0, "R1");
      for (int r = 0; r < NR; r++) expect_row(r, '0, "R1");

      // R2 full packet, R5 timing
      send(1, 8'h01);
      for (int k = 0; k < TOT - 1; k++) send(0, 8'h11 + 8'(k));
      expect_sync(1'b0, "R5 before last byte");
      send(0, 8'h16);
      expect_sync(1'b1, "R5 after last byte");
      expect_row(0, 16'h1211, "R2");
      expect_row(1, 16'h1413, "R2");
      expect_row(2, 16'h1615, "R2");
      expect_row(3, 16'h0000, "R10 out of range");

      // R6 byte beyond the packet
      send(0, 8'h77);
      expect_row(0, 16'h1211, "R6");
      expect_row(2, 16'h1615, "R6");

      // R7 ack clears
      pulse_ack();
      expect_sync(1'b0, "R7 ack");

      // R3 foreign address
      send(1, 8'h05);
      repeat (TOT) send(0, 8'hAA);
      expect_sync(1'b0, "R3");
      expect_row(0, 16'h1211, "R3");
      expect_row(1, 16'h1413, "R3");

      // R4 errors on data and address characters
      send(1, 8'h01);
      send(0, 8'h21); send(0, 8'h22);
      send(0, 8'h33, 0, 0, 1);
      for (int k = 0; k < 4; k++) send(0, 8'h51 + 8'(k));
      send(1, 8'h01, 1, 0, 0);
      send(0, 8'h61);
      send(1, 8'h01);
      send(0, 8'h62, 0, 1, 0);
      send(0, 8'h63);
      expect_sync(1'b0, "R4");
      expect_row(0, 16'h2221, "R4");
      expect_row(1, 16'h1413, "R4");
      expect_row(2, 16'h1615, "R4");

      // R8 restart mid-packet
      send(1, 8'h01);
      send(0, 8'h31); send(0, 8'h32); send(0, 8'h33);
      send(1, 8'h01);
      send(0, 8'h41); send(0, 8'h42);
      expect_row(0, 16'h4241, "R8 rewritten");
      expect_row(1, 16'h1433, "R8 kept");
      for (int k = 0; k < 3; k++) send(0, 8'h43 + 8'(k));
      expect_sync(1'b0, "R8 count restarted");
      send(0, 8'h46);
      expect_sync(1'b1, "R8 complete");
      expect_row(1, 16'h4443, "R8");
      expect_row(2, 16'h4645, "R8");
      pulse_ack();

      // R9 inputs ignored while not valid
      send(1, 8'h01);
      idle_junk(1, 8'h05);
      idle_junk(0, 8'h99);
      idle_junk(1, 8'h01);
      for (int k = 0; k < TOT - 1; k++) send(0, 8'h71 + 8'(k));
      expect_sync(1'b0, "R9");
      expect_row(0, 16'h7271, "R9");
      // R7 completion and ack on the same edge
      send(0, 8'h76, 0, 0, 0, 1);
      expect_sync(1'b1, "R7 set wins");
      expect_row(2, 16'h7675, "R2");
      pulse_ack();
      expect_sync(1'b0, "R7");

      repeat (2) @(posedge clk);
      #3;
      finish_run();
   end

endmodule